// File: doc/BRIEF.md
# Carrier edge-window demodulator

This block turns a carrier-modulated infrared input into a baseband mark/space level that a pulse-width receiver can time. It counts receive ticks between successive rising edges of the already synchronized input. A carrier is taken to be present when each rising edge arrives 16 ticks after the previous one, within a tolerance. The tolerance on the early side and the tolerance on the late side are each set to 3 or 4 ticks by their own bit of a 2-bit window field. With a receive tick of period T, the accepted carrier frequency therefore runs from 1/(T·(16+late)) up to 1/(T·(16−early)).

The first rising edge declares a mark. The mark holds as long as each following rising edge lands inside the window. An edge that comes too early ends the mark. So does the passing of 16+late ticks with no edge. When demodulation is disabled, the input is passed straight to the output and the tracking state is cleared. Clock division and FIFO storage belong to neighbouring blocks.

Top module: `ir_carrier_demod`

## Requirements
- R1: While rst_ni is low with demodulation enabled, level_o is 0 (space) whatever ir_i is.
- R2: With demod_en_i low, level_o equals ir_i. The mark state is cleared, so level_o is 0 in the first cycle after demodulation is enabled again, before any new rising edge.
- R3: With demodulation enabled and no mark held, a rising edge of ir_i (0 in one cycle, 1 in the next) sets level_o to 1 from the following cycle.
- R4: The early limit is 16−3 = 13 ticks when win_sel_i bit 0 is 0, and 16−4 = 12 ticks when it is 1. A held mark survives a rising edge whose gap from the previous accepted edge is at least this limit (and not above the late limit).
- R5: The late limit is 16+3 = 19 ticks when win_sel_i bit 1 is 0, and 16+4 = 20 ticks when it is 1. A held mark survives a rising edge whose gap equals this limit.
- R6: A rising edge arriving with a gap below the early limit ends a held mark; level_o is 0 from the following cycle.
- R7: If the gap grows past the late limit with no rising edge, the mark ends: level_o is 1 after the cycle that brings the gap to the late limit and 0 after the one that brings it one tick past. The next rising edge then declares a new mark.
- R8: The gap counts only cycles with tick_i high, including the tick in the cycle of the closing edge. Cycles with tick_i low neither age the gap nor cause a timeout.
- R9: Falling edges of ir_i have no effect on the mark; only rising edges are measured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_i | input | 1 | Synchronized IR input level |
| tick_i | input | 1 | Receive tick enable, one cycle per tick |
| demod_en_i | input | 1 | 1: demodulate carrier; 0: pass ir_i through |
| win_sel_i | input | 2 | Bit 0: early tolerance 4 (1) or 3 (0); bit 1: late tolerance 4 (1) or 3 (0) |
| level_o | output | 1 | Baseband level, 1 = mark, 0 = space |

## Verification
The assertions assume that win_sel_i changes only while demodulation is disabled. The bound on the gap of a held mark is only meaningful against a window that stays still for the whole mark. They also take ir_i as already synchronized to clk_i, so that each rising edge is seen in exactly one cycle. The stimulus keeps to both rules: it changes the window field only inside a disabled interval, and it drives ir_i away from the active clock edge. The sweep covers every window setting with edge gaps from 2 to 24 ticks, which reaches both sides of each limit and the timeout boundary.

// File: rtl/ir_demod_pkg.sv
package ir_demod_pkg;
  // Counter wide enough for saturation value plus one pending tick
  function automatic int unsigned gap_width(input int unsigned nom, input int unsigned tol_w);
    return $clog2(nom + tol_w + 3);
  endfunction

  typedef enum logic {
    SIDE_EARLY = 1'b0,
    SIDE_LATE  = 1'b1
  } win_side_e;
endpackage

// File: rtl/ir_rise_det.sv
module ir_rise_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ir_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= ir_i;
  end

  assign rise_o = ir_i & ~prev_q;
endmodule

// File: rtl/ir_win_lim.sv
module ir_win_lim #(
  parameter int unsigned NOM   = 16,
  parameter int unsigned TOL_N = 3,
  parameter int unsigned TOL_W = 4,
  parameter int unsigned CNT_W = 5
) (
  input  logic [1:0]       win_sel_i,
  output logic [CNT_W-1:0] lo_o,
  output logic [CNT_W-1:0] hi_o
);
  import ir_demod_pkg::*;

  logic [CNT_W-1:0] lim [2];

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic [CNT_W-1:0] tol;
    assign tol = win_sel_i[s] ? CNT_W'(TOL_W) : CNT_W'(TOL_N);
    if (s == int'(SIDE_EARLY)) begin : g_early
      assign lim[s] = CNT_W'(NOM) - tol;
    end else begin : g_late
      assign lim[s] = CNT_W'(NOM) + tol;
    end
  end

  assign lo_o = lim[int'(SIDE_EARLY)];
  assign hi_o = lim[int'(SIDE_LATE)];
endmodule

// File: rtl/ir_gap_ctr.sv
module ir_gap_ctr #(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned SAT   = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] elapsed_o,
  output logic [CNT_W-1:0] since_o
);
  logic [CNT_W-1:0] since_q;

  // elapsed includes the tick of the current cycle
  assign elapsed_o = since_q + CNT_W'(tick_i);
  assign since_o   = since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         since_q <= '0;
    else if (clr_i)                      since_q <= '0;
    else if (elapsed_o > CNT_W'(SAT))    since_q <= CNT_W'(SAT);
    else                                 since_q <= elapsed_o;
  end
endmodule

// File: rtl/ir_carrier_demod.sv
module ir_carrier_demod #(
  parameter int unsigned NOM_TICKS  = 16,
  parameter int unsigned TOL_NARROW = 3,
  parameter int unsigned TOL_WIDE   = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ir_i,
  input  logic       tick_i,
  input  logic       demod_en_i,
  input  logic [1:0] win_sel_i,
  output logic       level_o
);
  import ir_demod_pkg::*;

  localparam int unsigned CNT_W = gap_width(NOM_TICKS, TOL_WIDE);
  localparam int unsigned SAT   = NOM_TICKS + TOL_WIDE + 1;

  logic             rise_w;
  logic             mark_q;
  logic             mark_d;
  logic             in_win;
  logic [CNT_W-1:0] elapsed_w;
  logic [CNT_W-1:0] since_q;
  logic [CNT_W-1:0] lo_lim;
  logic [CNT_W-1:0] hi_lim;

  ir_rise_det u_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ir_i   (ir_i),
    .rise_o (rise_w)
  );

  ir_win_lim #(
    .NOM   (NOM_TICKS),
    .TOL_N (TOL_NARROW),
    .TOL_W (TOL_WIDE),
    .CNT_W (CNT_W)
  ) u_lim (
    .win_sel_i (win_sel_i),
    .lo_o      (lo_lim),
    .hi_o      (hi_lim)
  );

  ir_gap_ctr #(
    .CNT_W (CNT_W),
    .SAT   (SAT)
  ) u_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .clr_i     (rise_w | ~demod_en_i),
    .elapsed_o (elapsed_w),
    .since_o   (since_q)
  );

  assign in_win = (elapsed_w >= lo_lim) && (elapsed_w <= hi_lim);

  always_comb begin
    mark_d = mark_q;
    if (!demod_en_i)            mark_d = 1'b0;
    else if (rise_w)            mark_d = mark_q ? in_win : 1'b1;
    else if (elapsed_w > hi_lim) mark_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mark_q <= 1'b0;
    else         mark_q <= mark_d;
  end

  assign level_o = demod_en_i ? mark_q : ir_i;
endmodule

// File: rtl/ir_carrier_demod_chk.sv
module ir_carrier_demod_chk #(
  parameter int unsigned CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             demod_en_i,
  input logic             rise_w,
  input logic             mark_q,
  input logic [CNT_W-1:0] elapsed_w,
  input logic [CNT_W-1:0] since_q,
  input logic [CNT_W-1:0] lo_lim,
  input logic [CNT_W-1:0] hi_lim
);
  a_r2_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !demod_en_i |=> !mark_q);

  a_r3_first_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    demod_en_i && !mark_q && rise_w |=> mark_q && since_q == '0);

  a_r4_in_window_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    demod_en_i && mark_q && rise_w && elapsed_w >= lo_lim && elapsed_w <= hi_lim
    |=> mark_q && since_q == '0);

  a_r6_early_edge_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    demod_en_i && mark_q && rise_w && elapsed_w < lo_lim |=> !mark_q);

  a_r7_gap_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_q |-> since_q <= hi_lim);

  a_r8_no_tick_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    demod_en_i && !tick_i && !rise_w |=> $stable(mark_q) && $stable(since_q));
endmodule

bind ir_carrier_demod ir_carrier_demod_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .demod_en_i (demod_en_i),
  .rise_w     (rise_w),
  .mark_q     (mark_q),
  .elapsed_w  (elapsed_w),
  .since_q    (since_q),
  .lo_lim     (lo_lim),
  .hi_lim     (hi_lim)
);

// File: tb/ir_carrier_demod_test.sv
module ir_carrier_demod_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ir_i = 1'b0;
  logic       tick_i = 1'b0;
  logic       demod_en_i = 1'b0;
  logic [1:0] win_sel_i = 2'b00;
  logic       level_o;

  int tests = 0;
  int fails = 0;

  always #4 clk_i = ~clk_i;

  ir_carrier_demod uut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ir_i       (ir_i),
    .tick_i     (tick_i),
    .demod_en_i (demod_en_i),
    .win_sel_i  (win_sel_i),
    .level_o    (level_o)
  );

  task automatic chk(input string tag, input logic exp);
    tests++;
    if (level_o !== exp) begin
      fails++;
      $display("FAIL %s: level_o=%0b expected %0b", tag, level_o, exp);
    end
  endtask

  // disable for one cycle to clear, then enable with a new window
  task automatic restart(input logic [1:0] w);
    @(negedge clk_i);
    demod_en_i = 1'b0; ir_i = 1'b0;
    @(negedge clk_i);
    win_sel_i = w; demod_en_i = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset holds space when demodulating
    demod_en_i = 1'b1; ir_i = 1'b1;
    #20;
    chk("R1 reset space", 1'b0);
    ir_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after reset", 1'b0);

    // R2: passthrough
    demod_en_i = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      ir_i = i[0];
      #1;
      chk("R2 passthrough", i[0]);
    end
    @(negedge clk_i);
    ir_i = 1'b0;
    @(negedge clk_i);
    demod_en_i = 1'b1;
    #1;
    chk("R2 cleared on enable", 1'b0);

    // sweep of window settings and edge gaps, one tick per cycle
    tick_i = 1'b1;
    for (int w = 0; w < 4; w++) begin
      for (int g = 2; g <= 24; g++) begin
        int lo;
        int hi;
        logic exp_after;
        string tag;
        lo = 16 - (w[0] ? 4 : 3);
        hi = 16 + (w[1] ? 4 : 3);
        restart(w[1:0]);
        ir_i = 1'b1;
        @(negedge clk_i);
        chk("R3 first edge", 1'b1);
        ir_i = 1'b0;
        repeat (g - 1) @(negedge clk_i);
        chk("R7 timeout before edge", (g - 1) <= hi);
        ir_i = 1'b1;
        @(negedge clk_i);
        if (g - 1 > hi) begin
          exp_after = 1'b1; tag = "R7 new mark after timeout";
        end else if (g < lo) begin
          exp_after = 1'b0; tag = "R6 early edge";
        end else if (g <= hi) begin
          exp_after = 1'b1; tag = (g <= 16) ? "R4 early side held" : "R5 late side held";
        end else begin
          exp_after = 1'b0; tag = "R5 past late limit";
        end
        chk($sformatf("%s w=%0d gap=%0d", tag, w, g), exp_after);
        ir_i = 1'b0;
      end
    end

    // R8: gap counts only ticked cycles
    restart(2'b00);
    tick_i = 1'b0;
    ir_i = 1'b1;
    @(negedge clk_i);
    ir_i = 1'b0;
    repeat (100) @(negedge clk_i);
    chk("R8 no ticks no timeout", 1'b1);
    tick_i = 1'b1;
    repeat (15) @(negedge clk_i);
    ir_i = 1'b1;
    @(negedge clk_i);
    chk("R8 sixteen ticks held", 1'b1);
    ir_i = 1'b0;
    for (int i = 0; i < 32; i++) begin
      tick_i = i[0];
      @(negedge clk_i);
    end
    chk("R8 half-rate ticks no timeout", 1'b1);
    tick_i = 1'b0;
    ir_i = 1'b1;
    @(negedge clk_i);
    chk("R8 half-rate gap in window", 1'b1);
    ir_i = 1'b0;

    // R9: falling edges ignored
    tick_i = 1'b1;
    restart(2'b00);
    ir_i = 1'b1;
    @(negedge clk_i);
    repeat (9) @(negedge clk_i);
    ir_i = 1'b0;
    repeat (5) @(negedge clk_i);
    chk("R9 falling edge ignored", 1'b1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule